// File: doc/BRIEF.md
# Update-Based Snooping Coherence Controller

This block keeps the coherence state of every line of a direct-mapped, write-back cache that sits on a shared bus with a wired "copy present" signal. Each line is either absent or in one of four held states: exclusive-clean, shared-clean, shared-owned (dirty, other copies may exist) and owned (dirty, sole copy). Copies are never invalidated. When the local processor writes a line that other caches may hold, the controller broadcasts the word on the bus so the other holders refresh their copies, and the writer becomes the owner.

The processor side hands over one request at a time (read or write, by block address). The controller looks the line up and either completes the request locally or sequences the needed bus commands: write-back of a dirty victim, read fetch, write fetch and word update. Each command is held until the bus grants it. The controller then waits for the bus completion strobe and samples the combined shared signal there to pick the resulting state. At the same time it snoops commands from other caches. It raises its shared output when it holds the snooped block, flags that it must supply the data when its copy is dirty, and adjusts its own state. A snooped command always wins over a pending processor lookup. Data arrays and bus arbitration live elsewhere.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After reset every line is absent, `cpu_ready` is 1, and `bus_req`, `cpu_done`, `snp_shared` and `snp_supply` are 0.
- R2: A read of an absent or mismatched line whose victim is clean issues one read-fetch command (`bus_cmd` 0) with the requested address. The line becomes shared-clean if `bus_shared` is 1 at `bus_done`, otherwise exclusive-clean.
- R3: A read of a present line completes with no bus command. `cpu_done` pulses one cycle, two clock edges after the edge that accepts `cpu_req`, and then `cpu_hit` is 1. `cpu_hit` is 0 for any request that had to fetch.
- R4: A write to a present exclusive-clean or owned line completes with no bus command and leaves the line owned.
- R5: A write to a present shared-clean or shared-owned line issues one update command (`bus_cmd` 2) with the line address and never writes memory. The line becomes shared-owned if `bus_shared` is 1 at `bus_done`, otherwise owned.
- R6: A write miss issues a write-fetch command (`bus_cmd` 1). If `bus_shared` was 1 at its completion, an update command follows and the line ends as in R5. Otherwise the line becomes owned with no update.
- R7: On a miss whose victim line is shared-owned or owned, a write-back command (`bus_cmd` 3) carrying the victim's address goes out before the fetch, and the victim is gone afterwards. A clean victim is dropped with no write-back. `bus_shared` is ignored for a write-back.
- R8: A snooped read fetch (0) or write fetch (1) that hits a held line raises `snp_shared` one cycle later. It raises `snp_supply` with it only if the line is shared-owned or owned. Exclusive-clean becomes shared-clean, owned becomes shared-owned, and the other states are kept.
- R9: A snooped update (2) that hits a held line raises `snp_shared` and never `snp_supply`. Any held line becomes shared-clean, and the line is never removed.
- R10: A snooped command that misses, and any snooped write-back (3), leaves `snp_shared` and `snp_supply` at 0 and changes no state.
- R11: While `snp_valid` is 1, an accepted processor request does not advance: no `cpu_done` and no bus request appear until one cycle after `snp_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle request strobe, taken when `cpu_ready` is 1 |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address of the request |
| cpu_ready | output | 1 | Controller idle, may take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Request found its line present (valid with `cpu_done`) |
| bus_req | output | 1 | Command pending, held until `bus_gnt` |
| bus_cmd | output | 2 | 0 read fetch, 1 write fetch, 2 word update, 3 write-back |
| bus_addr | output | ADDR_W | Block address of the command |
| bus_gnt | input | 1 | Command taken by the bus this cycle |
| bus_done | input | 1 | Bus transaction complete, `bus_shared` valid |
| bus_shared | input | 1 | Combined shared signal of the other caches |
| snp_valid | input | 1 | Another cache's command is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_shared | output | 1 | This cache holds the snooped block |
| snp_supply | output | 1 | This cache holds it dirty and supplies the data |

## Verification
All results come from registers. The snoop outputs are due one edge after the cycle where `snp_valid` is high. A request that is found locally completes two edges after the accepting edge. The first bus command shows on `bus_req` at that same second edge. After each `bus_done`, the next command or the completion pulse appears one edge later. The bench drives inputs on falling edges and reads the outputs on the next falling edge after the edge that is due. It handles the grant and done strobes in the same rhythm and records every command the controller issues. A small behavioural model of the line states predicts the command list and the snoop responses across a long mixed sweep over all addresses of a four-line configuration. Directed sequences pin the exact completion latency and the stall under a held snoop.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [2:0] {
    LS_ABSENT  = 3'd0,
    LS_EXCL    = 3'd1,
    LS_SHCLEAN = 3'd2,
    LS_SHOWNED = 3'd3,
    LS_OWNED   = 3'd4
  } line_st_t;

  typedef enum logic [1:0] {
    BC_RDFETCH = 2'd0,
    BC_WRFETCH = 2'd1,
    BC_UPDATE  = 2'd2,
    BC_WRBACK  = 2'd3
  } bus_cmd_t;

  // Line holds data newer than memory
  function automatic logic st_dirty(line_st_t s);
    return (s == LS_SHOWNED) || (s == LS_OWNED);
  endfunction

  // Line may have copies elsewhere, so a write must be broadcast
  function automatic logic st_maybe_shared(line_st_t s);
    return (s == LS_SHCLEAN) || (s == LS_SHOWNED);
  endfunction

  function automatic line_st_t after_fetch(logic sh);
    return sh ? LS_SHCLEAN : LS_EXCL;
  endfunction

  function automatic line_st_t after_update(logic sh);
    return sh ? LS_SHOWNED : LS_OWNED;
  endfunction

  // State change of a held line when another cache's command hits it
  function automatic line_st_t snoop_next(line_st_t s, bus_cmd_t c);
    line_st_t n;
    n = s;
    case (c)
      BC_RDFETCH, BC_WRFETCH: begin
        if (s == LS_EXCL)       n = LS_SHCLEAN;
        else if (s == LS_OWNED) n = LS_SHOWNED;
      end
      BC_UPDATE: begin
        if (s != LS_ABSENT) n = LS_SHCLEAN;
      end
      default: n = s;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  // processor-side read port
  input  logic [IDX_W-1:0] p_idx,
  output line_st_t         p_st,
  output logic [TAG_W-1:0] p_tag,
  // snoop-side read port
  input  logic [IDX_W-1:0] s_idx,
  output line_st_t         s_st,
  output logic [TAG_W-1:0] s_tag,
  // snoop-side state write
  input  logic             s_we,
  input  line_st_t         s_nst,
  // sequencer-side state and tag write
  input  logic             f_we,
  input  logic [IDX_W-1:0] f_idx,
  input  line_st_t         f_nst,
  input  logic             f_tag_we,
  input  logic [TAG_W-1:0] f_tag
);

  localparam int LINES = 1 << IDX_W;

  // Tags need no reset: a line is only matched when its state is held
  logic [TAG_W-1:0] tag_mem [LINES];

  always_ff @(posedge clk) begin
    if (f_tag_we) tag_mem[f_idx] <= f_tag;
  end

  assign p_tag = tag_mem[p_idx];
  assign s_tag = tag_mem[s_idx];

  // State bits live in flops so that reset clears every line at once
  logic [LINES-1:0][2:0] st_vec;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_t st_r;
    always_ff @(posedge clk) begin
      if (rst)                                    st_r <= LS_ABSENT;
      else if (f_we && (f_idx == IDX_W'(g)))      st_r <= f_nst;
      else if (s_we && (s_idx == IDX_W'(g)))      st_r <= s_nst;
    end
    assign st_vec[g] = st_r;
  end

  assign p_st = line_st_t'(st_vec[p_idx]);
  assign s_st = line_st_t'(st_vec[s_idx]);

endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  // line store access
  output logic [IDX_W-1:0]  s_idx,
  input  line_st_t          s_st,
  input  logic [TAG_W-1:0]  s_tag,
  output logic              s_we,
  output line_st_t          s_nst,
  // bus responses
  output logic              snp_shared,
  output logic              snp_supply
);

  bus_cmd_t cmd;
  logic     held;
  logic     is_fetch;
  logic     shared_q, supply_q;

  assign cmd      = bus_cmd_t'(snp_cmd);
  assign s_idx    = snp_addr[IDX_W-1:0];
  assign held     = snp_valid && (s_st != LS_ABSENT) && (s_tag == snp_addr[ADDR_W-1:IDX_W]);
  assign is_fetch = (cmd == BC_RDFETCH) || (cmd == BC_WRFETCH);

  assign s_we  = held && (cmd != BC_WRBACK);
  assign s_nst = snoop_next(s_st, cmd);

  always_ff @(posedge clk) begin
    if (rst) begin
      shared_q <= 1'b0;
      supply_q <= 1'b0;
    end else begin
      shared_q <= held && (cmd != BC_WRBACK);
      supply_q <= held && is_fetch && st_dirty(s_st);
    end
  end

  assign snp_shared = shared_q;
  assign snp_supply = supply_q;

endmodule

// File: rtl/coh_req_seq.sv
module coh_req_seq
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  // processor side
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic              cpu_hit,
  // snoop priority
  input  logic              snp_valid,
  // bus side
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic              bus_shared,
  // line store access
  output logic [IDX_W-1:0]  p_idx,
  input  line_st_t          p_st,
  input  logic [TAG_W-1:0]  p_tag,
  output logic              f_we,
  output logic [IDX_W-1:0]  f_idx,
  output line_st_t          f_nst,
  output logic              f_tag_we,
  output logic [TAG_W-1:0]  f_tag
);

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_REQ, S_RESP} seq_t;

  seq_t              seq_q, seq_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  bus_cmd_t          cmd_q, cmd_d;
  logic [ADDR_W-1:0] baddr_q, baddr_d;
  logic              breq_q, breq_d;
  logic              done_q, done_d;
  logic              hit_q, hit_d;
  logic              present;

  assign p_idx    = addr_q[IDX_W-1:0];
  assign f_idx    = addr_q[IDX_W-1:0];
  assign f_tag    = addr_q[ADDR_W-1:IDX_W];
  assign present  = (p_st != LS_ABSENT) && (p_tag == addr_q[ADDR_W-1:IDX_W]);

  always_comb begin
    seq_d    = seq_q;
    wr_d     = wr_q;
    addr_d   = addr_q;
    cmd_d    = cmd_q;
    baddr_d  = baddr_q;
    breq_d   = breq_q;
    done_d   = 1'b0;
    hit_d    = hit_q;
    f_we     = 1'b0;
    f_nst    = LS_ABSENT;
    f_tag_we = 1'b0;
    case (seq_q)
      S_IDLE: begin
        if (cpu_req) begin
          wr_d   = cpu_wr;
          addr_d = cpu_addr;
          hit_d  = 1'b0;
          seq_d  = S_LOOK;
        end
      end
      S_LOOK: begin
        // a snooped command owns the store this cycle
        if (!snp_valid) begin
          if (present && !wr_q) begin
            hit_d  = 1'b1;
            done_d = 1'b1;
            seq_d  = S_IDLE;
          end else if (present && !st_maybe_shared(p_st)) begin
            f_we   = 1'b1;
            f_nst  = LS_OWNED;
            hit_d  = 1'b1;
            done_d = 1'b1;
            seq_d  = S_IDLE;
          end else if (present) begin
            hit_d   = 1'b1;
            cmd_d   = BC_UPDATE;
            baddr_d = addr_q;
            breq_d  = 1'b1;
            seq_d   = S_REQ;
          end else if (st_dirty(p_st)) begin
            cmd_d   = BC_WRBACK;
            baddr_d = {p_tag, addr_q[IDX_W-1:0]};
            breq_d  = 1'b1;
            seq_d   = S_REQ;
          end else begin
            cmd_d   = wr_q ? BC_WRFETCH : BC_RDFETCH;
            baddr_d = addr_q;
            breq_d  = 1'b1;
            seq_d   = S_REQ;
          end
        end
      end
      S_REQ: begin
        if (bus_gnt) begin
          breq_d = 1'b0;
          seq_d  = S_RESP;
        end
      end
      S_RESP: begin
        if (bus_done) begin
          case (cmd_q)
            BC_WRBACK: begin
              f_we    = 1'b1;
              f_nst   = LS_ABSENT;
              cmd_d   = wr_q ? BC_WRFETCH : BC_RDFETCH;
              baddr_d = addr_q;
              breq_d  = 1'b1;
              seq_d   = S_REQ;
            end
            BC_RDFETCH: begin
              f_we     = 1'b1;
              f_tag_we = 1'b1;
              f_nst    = after_fetch(bus_shared);
              done_d   = 1'b1;
              seq_d    = S_IDLE;
            end
            BC_WRFETCH: begin
              f_we     = 1'b1;
              f_tag_we = 1'b1;
              if (bus_shared) begin
                f_nst   = LS_SHCLEAN;
                cmd_d   = BC_UPDATE;
                baddr_d = addr_q;
                breq_d  = 1'b1;
                seq_d   = S_REQ;
              end else begin
                f_nst  = LS_OWNED;
                done_d = 1'b1;
                seq_d  = S_IDLE;
              end
            end
            default: begin
              f_we   = 1'b1;
              f_nst  = after_update(bus_shared);
              done_d = 1'b1;
              seq_d  = S_IDLE;
            end
          endcase
        end
      end
      default: seq_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q   <= S_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      cmd_q   <= BC_RDFETCH;
      baddr_q <= '0;
      breq_q  <= 1'b0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      seq_q   <= seq_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      cmd_q   <= cmd_d;
      baddr_q <= baddr_d;
      breq_q  <= breq_d;
      done_q  <= done_d;
      hit_q   <= hit_d;
    end
  end

  assign cpu_ready = (seq_q == S_IDLE);
  assign cpu_done  = done_q;
  assign cpu_hit   = hit_q;
  assign bus_req   = breq_q;
  assign bus_cmd   = cmd_q;
  assign bus_addr  = baddr_q;

endmodule

// File: rtl/upd_coh_ctrl.sv
module upd_coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic              bus_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply
);

  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] p_idx, s_idx, f_idx;
  line_st_t         p_st, s_st, s_nst, f_nst;
  logic [TAG_W-1:0] p_tag, s_tag, f_tag;
  logic             s_we, f_we, f_tag_we;

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .p_idx    (p_idx),
    .p_st     (p_st),
    .p_tag    (p_tag),
    .s_idx    (s_idx),
    .s_st     (s_st),
    .s_tag    (s_tag),
    .s_we     (s_we),
    .s_nst    (s_nst),
    .f_we     (f_we),
    .f_idx    (f_idx),
    .f_nst    (f_nst),
    .f_tag_we (f_tag_we),
    .f_tag    (f_tag)
  );

  coh_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snoop (
    .clk        (clk),
    .rst        (rst),
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .snp_addr   (snp_addr),
    .s_idx      (s_idx),
    .s_st       (s_st),
    .s_tag      (s_tag),
    .s_we       (s_we),
    .s_nst      (s_nst),
    .snp_shared (snp_shared),
    .snp_supply (snp_supply)
  );

  coh_req_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .cpu_wr     (cpu_wr),
    .cpu_addr   (cpu_addr),
    .cpu_ready  (cpu_ready),
    .cpu_done   (cpu_done),
    .cpu_hit    (cpu_hit),
    .snp_valid  (snp_valid),
    .bus_req    (bus_req),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .bus_gnt    (bus_gnt),
    .bus_done   (bus_done),
    .bus_shared (bus_shared),
    .p_idx      (p_idx),
    .p_st       (p_st),
    .p_tag      (p_tag),
    .f_we       (f_we),
    .f_idx      (f_idx),
    .f_nst      (f_nst),
    .f_tag_we   (f_tag_we),
    .f_tag      (f_tag)
  );

endmodule

// File: rtl/coh_chk.sv
module coh_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ready,
  input logic              cpu_done,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_done,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_shared,
  input logic              snp_supply
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cpu_ready && !bus_req && !cpu_done && !snp_shared && !snp_supply));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> cpu_ready);

  p_wb_then_fetch_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_done) && ($past(bus_cmd) == 2'd3)) |-> (bus_req && (bus_cmd[1] == 1'b0)));

  p_supply_shared_r8: assert property (@(posedge clk) disable iff (rst)
    snp_supply |-> snp_shared);

  p_update_no_supply_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(snp_valid) && ($past(snp_cmd) == 2'd2)) |-> !snp_supply);

  p_snoop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(snp_valid) |-> (!snp_shared && !snp_supply));

  p_snoop_first_r11: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) || $rose(cpu_done)) |-> !$past(snp_valid));

endmodule

bind upd_coh_ctrl coh_chk #(.ADDR_W(ADDR_W)) u_coh_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_ready  (cpu_ready),
  .cpu_done   (cpu_done),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .bus_cmd    (bus_cmd),
  .bus_addr   (bus_addr),
  .bus_done   (bus_done),
  .snp_valid  (snp_valid),
  .snp_cmd    (snp_cmd),
  .snp_shared (snp_shared),
  .snp_supply (snp_supply)
);

// File: tb/test_upd_coh_ctrl.sv
module test_upd_coh_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 4;
  localparam int IW = 2;
  localparam int NL = 1 << IW;
  // bench-side model states
  localparam int M_ABS = 0, M_EX = 1, M_SC = 2, M_SO = 3, M_OW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req = 1'b0, cpu_wr = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_ready, cpu_done, cpu_hit;
  logic          bus_req;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic          bus_gnt = 1'b0, bus_done = 1'b0, bus_shared = 1'b0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_shared, snp_supply;

  int n_vec = 0;
  int n_bad = 0;
  int m_st  [NL];
  int m_tag [NL];

  always #5 clk = ~clk;

  upd_coh_ctrl #(.ADDR_W(AW), .IDX_W(IW)) i_upd_coh_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_shared(bus_shared),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_supply(snp_supply)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Processor request: predict from the model, then drive and record bus commands
  task automatic do_cpu(input logic wr, input logic [AW-1:0] a, input logic shf, input logic shu);
    int idx, tg, st, n, got_n, cur;
    int ec [4];
    int ea [4];
    int gc [4];
    int ga [4];
    logic ehit, ghit, fin;
    string rq;
    idx = int'(a[IW-1:0]);
    tg  = int'(a[AW-1:IW]);
    st  = m_st[idx];
    n   = 0;
    ehit = (st != M_ABS) && (m_tag[idx] == tg);
    if (ehit) begin
      if (!wr) rq = "R3";
      else if (st == M_EX || st == M_OW) begin m_st[idx] = M_OW; rq = "R4"; end
      else begin
        ec[0] = 2; ea[0] = int'(a); n = 1;
        m_st[idx] = shu ? M_SO : M_OW; rq = "R5";
      end
    end else begin
      rq = wr ? "R6" : "R2";
      if (st == M_SO || st == M_OW) begin
        ec[n] = 3; ea[n] = m_tag[idx] * NL + idx; n++; rq = "R7";
      end
      if (!wr) begin
        ec[n] = 0; ea[n] = int'(a); n++;
        m_st[idx] = shf ? M_SC : M_EX;
      end else begin
        ec[n] = 1; ea[n] = int'(a); n++;
        if (shf) begin
          ec[n] = 2; ea[n] = int'(a); n++;
          m_st[idx] = shu ? M_SO : M_OW;
        end else m_st[idx] = M_OW;
      end
      m_tag[idx] = tg;
    end

    @(negedge clk);
    chk("R3", "cpu_ready before request", int'(cpu_ready), 1);
    cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a;
    @(negedge clk);
    cpu_req = 1'b0;
    got_n = 0; fin = 1'b0; ghit = 1'b0;
    for (int cyc = 0; cyc < 40 && !fin; cyc++) begin
      if (cpu_done) begin
        fin = 1'b1; ghit = cpu_hit;
      end else if (bus_req) begin
        cur = int'(bus_cmd);
        if (got_n < 4) begin gc[got_n] = cur; ga[got_n] = int'(bus_addr); end
        got_n++;
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0; bus_done = 1'b1;
        bus_shared = (cur == 2) ? shu : ((cur == 3) ? 1'b1 : shf);
        @(negedge clk);
        bus_done = 1'b0; bus_shared = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk(rq, "request completed", int'(fin), 1);
    chk(rq, "bus command count", got_n, n);
    for (int k = 0; k < n && k < got_n; k++) begin
      chk(rq, "bus command code", gc[k], ec[k]);
      chk(rq, "bus command address", ga[k], ea[k]);
    end
    chk("R3", "cpu_hit flag", int'(ghit), int'(ehit));
  endtask

  task automatic do_snoop(input logic [1:0] c, input logic [AW-1:0] a);
    int idx, st, esh, esu;
    logic held;
    string rq;
    idx  = int'(a[IW-1:0]);
    st   = m_st[idx];
    held = (st != M_ABS) && (m_tag[idx] == int'(a[AW-1:IW]));
    esh = 0; esu = 0;
    if (!held || c == 2'd3) rq = "R10";
    else if (c == 2'd2) begin
      rq = "R9"; esh = 1; m_st[idx] = M_SC;
    end else begin
      rq = "R8"; esh = 1;
      esu = (st == M_SO || st == M_OW) ? 1 : 0;
      if (st == M_EX) m_st[idx] = M_SC;
      else if (st == M_OW) m_st[idx] = M_SO;
    end
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    chk(rq, "snp_shared", int'(snp_shared), esh);
    chk(rq, "snp_supply", int'(snp_supply), esu);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    logic [AW-1:0] a;
    logic [2:0] op;
    for (int i = 0; i < NL; i++) begin m_st[i] = M_ABS; m_tag[i] = 0; end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs right after reset
    chk("R1", "cpu_ready", int'(cpu_ready), 1);
    chk("R1", "bus_req", int'(bus_req), 0);
    chk("R1", "cpu_done", int'(cpu_done), 0);
    chk("R1", "snp_shared", int'(snp_shared), 0);
    chk("R1", "snp_supply", int'(snp_supply), 0);
    // R1: every address absent, so every snooped fetch misses
    for (int k = 0; k < (1 << AW); k++) do_snoop(2'd0, AW'(k));

    // R3: exact completion latency of a read that finds its line
    do_cpu(1'b0, 4'd6, 1'b0, 1'b0);
    @(negedge clk);
    cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = 4'd6;
    @(negedge clk);
    cpu_req = 1'b0;
    chk("R3", "cpu_done one edge after accept", int'(cpu_done), 0);
    chk("R3", "no bus_req on read hit", int'(bus_req), 0);
    @(negedge clk);
    chk("R3", "cpu_done two edges after accept", int'(cpu_done), 1);
    chk("R3", "cpu_hit on read hit", int'(cpu_hit), 1);
    chk("R3", "no bus_req on read hit", int'(bus_req), 0);
    @(negedge clk);
    chk("R3", "cpu_done is a single pulse", int'(cpu_done), 0);

    // R11: a held snoop stalls an accepted request
    do_cpu(1'b0, 4'd5, 1'b0, 1'b0);
    @(negedge clk);
    cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = 4'd5;
    snp_valid = 1'b1; snp_cmd = 2'd3; snp_addr = 4'd9;
    @(negedge clk);
    cpu_req = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R11", "cpu_done while snooping", int'(cpu_done), 0);
      chk("R11", "bus_req while snooping", int'(bus_req), 0);
      @(negedge clk);
    end
    snp_valid = 1'b0;
    chk("R11", "cpu_done still low as snoop drops", int'(cpu_done), 0);
    @(negedge clk);
    chk("R11", "cpu_done one edge after snoop drops", int'(cpu_done), 1);
    chk("R11", "cpu_hit after stall", int'(cpu_hit), 1);
    chk("R10", "snooped write-back leaves snp_shared low", int'(snp_shared), 0);

    // Directed state walks on index 3 (R4, R5, R6, R7, R8, R9)
    do_cpu(1'b1, 4'd3, 1'b0, 1'b0);   // R6 write miss alone -> owned
    do_cpu(1'b1, 4'd3, 1'b0, 1'b0);   // R4 local write
    do_snoop(2'd0, 4'd3);             // R8 supply, owned -> shared-owned
    do_cpu(1'b1, 4'd3, 1'b0, 1'b1);   // R5 update, still shared -> shared-owned
    do_snoop(2'd2, 4'd3);             // R9 foreign update -> shared-clean
    do_snoop(2'd1, 4'd3);             // R8 clean holder, no supply
    do_cpu(1'b1, 4'd3, 1'b0, 1'b0);   // R5 update alone -> owned
    do_cpu(1'b1, 4'd7, 1'b1, 1'b1);   // R7 write-back then R6 fetch plus update
    do_snoop(2'd0, 4'd3);             // R7 victim now absent
    do_snoop(2'd0, 4'd7);             // R8 shared-owned supplies

    // Mixed sweep over every address and operation
    lf = 16'hACE1;
    for (int k = 0; k < 2500; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a  = lf[3:0];
      op = lf[7:5];
      if (op < 3'd4) do_cpu(op[0], a, lf[8], lf[9]);
      else           do_snoop(op[1:0], a);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule